// File: doc/BRIEF.md
# System Bus Region Decoder and Acknowledge Generator

This block sits on an asynchronous system bus that has 22 word-address lines, separate upper and lower byte strobes and an active-low chip select. The byte address is the word address shifted left by one. Each access falls into one of five regions: DRAM, system ROM, system I/O, or one of two internal register banks. The block drives active-low chip selects for the ROM and I/O regions. It also produces an active-low data acknowledge whose timing depends on the region.

DRAM accesses wait for a ready input from an external memory controller. ROM accesses wait for a programmable number of clocks, taken from a 3-bit delay field that a register-write port loads. Register-bank accesses wait a fixed 2 clocks. I/O accesses are never acknowledged by this block, because the addressed device answers for itself. If the strobes are released before the acknowledge is produced, that acknowledge is dropped.

Chip select and both strobes pass through a two-flop synchronizer before use. There is no read/write input, because nothing in the block depends on the transfer direction. In particular, the ROM select is driven for both reads and writes, so static RAM can be mapped there.

Top module: `bus_ack_decoder`

## Requirements
- R1: After reset, `dtack_n`, `rom_cs_n` and `io_cs_n` are all high, and the ROM delay field holds code 000.
- R2: With a synchronized access active, the word address selects the region. Below 0x200000 is DRAM. 0x200000 to 0x27FDFF is ROM, and `rom_cs_n` is low. 0x27FE00 to 0x27FFEF is I/O, and `io_cs_n` is low. 0x27FFF0 to 0x27FFFF is the register banks. Neither chip select is low for DRAM, the register banks or unmapped addresses, and the two selects are never low together.
- R3: With `cs_n` high, strobe activity produces no chip select and no acknowledge.
- R4: For ROM, `dtack_n` first reads low in the clock period after the (N+2)th rising edge that follows the strobe change. N is 11 when the delay code's bit 2 is 0, and 3, 5, 7 or 9 for codes 100, 101, 110 or 111.
- R5: A cycle with `cfg_we` high loads `cfg_delay` into the delay field. Before any write, the ROM wait is 11 clocks.
- R6: A register-bank access is acknowledged with N = 2 under the same counting as R4.
- R7: A DRAM access is acknowledged on the edge after `dram_ready` is sampled high, counting only from the third edge after the strobe change.
- R8: Accesses to I/O, and to word addresses above 0x27FFFF, are never acknowledged.
- R9: If both strobes go high before the acknowledge is produced, no acknowledge is produced for that access.
- R10: After both strobes go high during an acknowledge, `dtack_n` stays low for two more edges and is high after the third.
- R11: Either strobe alone starts an access, and so do both together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 22 | Word address, held stable during an access |
| cs_n | input | 1 | Bus chip select, active low, asynchronous |
| uds_n | input | 1 | Upper byte strobe, active low, asynchronous |
| lds_n | input | 1 | Lower byte strobe, active low, asynchronous |
| dram_ready | input | 1 | DRAM data-valid indication from the memory controller |
| cfg_we | input | 1 | Write enable for the ROM delay field |
| cfg_delay | input | 3 | New ROM delay code |
| rom_cs_n | output | 1 | ROM region chip select, active low |
| io_cs_n | output | 1 | I/O region chip select, active low |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The assertions assume three things. The address is stable from the strobe change until the acknowledge has been released. `dram_ready` is synchronous to the clock. Each access ends with both strobes high long enough for the controller to return to idle before the next one starts.

The stimulus respects these assumptions. It drives the address, selects and strobes only on falling clock edges, holds the address for the whole access, and releases `cs_n` and `dram_ready` after each access. It then leaves several idle cycles before starting the next access.

Random accesses cover all regions, strobe patterns, delay-code rewrites and early cancellations. These are mixed with directed hits on every region edge.

// File: rtl/bus_ack_decoder.sv
module bus_ack_decoder #(
  parameter int AW       = 22,
  parameter int CW       = 4,
  parameter int REG_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          cs_n,
  input  logic          uds_n,
  input  logic          lds_n,
  input  logic          dram_ready,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_delay,
  output logic          rom_cs_n,
  output logic          io_cs_n,
  output logic          dtack_n
);

  localparam logic [AW-1:0] ROM_LO = AW'(32'h200000);
  localparam logic [AW-1:0] IO_LO  = AW'(32'h27FE00);
  localparam logic [AW-1:0] REG_LO = AW'(32'h27FFF0);
  localparam logic [AW-1:0] REG_HI = AW'(32'h27FFFF);

  typedef enum logic [2:0] {ST_IDLE, ST_CNT, ST_DRAM, ST_HOLD, ST_ACK} st_t;

  logic [2:0]    sync1, sync2;
  logic [2:0]    dly_q;
  logic [CW-1:0] cnt_q, rom_wait;
  st_t           st_q;
  logic          acc, is_dram, is_rom, is_io, is_reg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 3'b111;
      sync2 <= 3'b111;
    end else begin
      sync1 <= {cs_n, uds_n, lds_n};
      sync2 <= sync1;
    end

  assign acc     = ~sync2[2] & ~(sync2[1] & sync2[0]);
  assign is_dram = bus_addr < ROM_LO;
  assign is_rom  = (bus_addr >= ROM_LO) && (bus_addr < IO_LO);
  assign is_io   = (bus_addr >= IO_LO) && (bus_addr < REG_LO);
  assign is_reg  = (bus_addr >= REG_LO) && (bus_addr <= REG_HI);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dly_q <= 3'b000;
    else if (cfg_we) dly_q <= cfg_delay;

  assign rom_wait = dly_q[2] ? CW'(3 + 2 * dly_q[1:0]) : CW'(11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:
          if (acc) begin
            if (is_rom) begin
              st_q  <= ST_CNT;
              cnt_q <= rom_wait - CW'(2);
            end else if (is_reg) begin
              st_q  <= ST_CNT;
              cnt_q <= CW'(REG_WAIT - 2);
            end else if (is_dram) st_q <= ST_DRAM;
            else                  st_q <= ST_HOLD;
          end
        ST_CNT:
          if (!acc)             st_q <= ST_IDLE;
          else if (cnt_q == '0) st_q <= ST_ACK;
          else                  cnt_q <= cnt_q - CW'(1);
        ST_DRAM:
          if (!acc)            st_q <= ST_IDLE;
          else if (dram_ready) st_q <= ST_ACK;
        default:
          if (!acc) st_q <= ST_IDLE;
      endcase
    end

  assign dtack_n  = (st_q != ST_ACK);
  assign rom_cs_n = ~(acc & is_rom);
  assign io_cs_n  = ~(acc & is_io);

  // R8
  io_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cs_n |-> dtack_n);

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> dtack_n);

  // R9
  ack_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(acc));

  // R7
  dram_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dtack_n) && is_dram) |-> $past(dram_ready));

  // R2
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !io_cs_n));

endmodule

// File: tb/bus_ack_decoder_bench.sv
module bus_ack_decoder_bench;
  logic        clk = 0, rst_n = 0;
  logic [21:0] bus_addr = '0;
  logic        cs_n = 1, uds_n = 1, lds_n = 1, dram_ready = 0, cfg_we = 0;
  logic [2:0]  cfg_delay = '0;
  logic        rom_cs_n, io_cs_n, dtack_n;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [2:0]  code_m = 3'b000;

  always #2 clk = ~clk;

  bus_ack_decoder u_bus_ack_decoder (.clk, .rst_n, .bus_addr, .cs_n, .uds_n, .lds_n,
    .dram_ready, .cfg_we, .cfg_delay, .rom_cs_n, .io_cs_n, .dtack_n);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int rom_n(input logic [2:0] c);
    return c[2] ? 3 + 2 * c[1:0] : 11;
  endfunction

  function automatic int region(input logic [21:0] a);
    if (a < 22'h200000) return 0;
    if (a < 22'h27FE00) return 1;
    if (a < 22'h27FFF0) return 2;
    if (a <= 22'h27FFFF) return 3;
    return 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_delay(input logic [2:0] c);
    cfg_delay = c; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    code_m = c;
  endtask

  // one access; cancel_at>0 releases strobes early, ready_at>0 raises dram_ready
  task automatic access(input logic [21:0] a, input logic [1:0] stb, input bit sel,
                        input int cancel_at, input int ready_at, input string tag);
    int r = region(a), exp = 0, got = -1;
    if (sel && cancel_at == 0) begin
      if (r == 1) exp = rom_n(code_m) + 2;
      else if (r == 3) exp = 4;
      else if (r == 0 && ready_at > 0) exp = (ready_at > 3 ? ready_at : 3) + 1;
    end
    bus_addr = a; cs_n = !sel; {uds_n, lds_n} = stb;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 2 && cancel_at == 0) begin
        chk({tag, " R2 rom_cs"}, rom_cs_n, !(sel && r == 1));
        chk({tag, " R2 io_cs"}, io_cs_n, !(sel && r == 2));
      end
      if (!dtack_n && got < 0) got = i;
      if (i == ready_at) dram_ready = 1;
      if (i == cancel_at) {uds_n, lds_n} = 2'b11;
      if (got > 0) break;
    end
    chk({tag, " ack cycle"}, got, exp > 0 ? exp : -1);
    {uds_n, lds_n} = 2'b11;
    if (got > 0) begin
      @(negedge clk); @(negedge clk);
      chk("R10 held two edges", dtack_n, 0);
      @(negedge clk);
      chk("R10 released third edge", dtack_n, 1);
    end
    cs_n = 1; dram_ready = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 dtack_n", dtack_n, 1);
    chk("R1 rom_cs_n", rom_cs_n, 1);
    chk("R1 io_cs_n", io_cs_n, 1);
    rst_n = 1;
    @(negedge clk);
    access(22'h200000, 2'b00, 1, 0, 0, "R5 default");
    for (int c = 0; c < 8; c++) begin
      set_delay(3'(c));
      access(22'h27FDFF, 2'b00, 1, 0, 0, "R4");
    end
    access(22'h27FFF0, 2'b00, 1, 0, 0, "R6");
    access(22'h27FFFF, 2'b01, 1, 0, 0, "R6");
    access(22'h1FFFFF, 2'b00, 1, 0, 2, "R7 early ready");
    access(22'h000000, 2'b00, 1, 0, 9, "R7 late ready");
    access(22'h27FE00, 2'b00, 1, 0, 0, "R8 io");
    access(22'h27FFEF, 2'b00, 1, 0, 0, "R8 io top");
    access(22'h280000, 2'b00, 1, 0, 0, "R8 unmapped");
    access(22'h200000, 2'b00, 0, 0, 0, "R3 no select");
    set_delay(3'b111);
    access(22'h200004, 2'b00, 1, 5, 0, "R9 rom cancel");
    access(22'h27FFF4, 2'b00, 1, 1, 0, "R9 reg cancel");
    access(22'h200010, 2'b01, 1, 0, 0, "R11 lower only");
    access(22'h200010, 2'b10, 1, 0, 0, "R11 upper only");
    for (int k = 0; k < 80; k++) begin
      int rg = $urandom % 5, cn = 0, rd = 0;
      logic [21:0] a;
      logic [1:0] stb = 2'($urandom % 3);
      if ($urandom % 4 == 0) set_delay(3'($urandom));
      case (rg)
        0: a = 22'($urandom) & 22'h1FFFFF;
        1: a = 22'h200000 + 22'($urandom % 32'h7FE00);
        2: a = 22'h27FE00 + 22'($urandom % 32'h1F0);
        3: a = 22'h27FFF0 + 22'($urandom % 16);
        default: a = 22'h280000 + 22'($urandom % 32'h180000);
      endcase
      if (rg == 0) rd = 1 + $urandom % 10;
      if ($urandom % 5 == 0) begin
        if (rg == 1) cn = 1 + $urandom % (rom_n(code_m) - 1);
        else if (rg == 3) cn = 1;
        else if (rg == 0) begin cn = 1 + $urandom % 8; rd = 0; end
      end
      access(a, stb, 1, cn, rd, "R2 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule